// File: doc/BRIEF.md
# I2C Slave Register Access Layer

This block sits behind an I2C slave byte engine and turns its byte strobes into accesses to a small register map. The byte engine handles START/STOP detection, bit shifting and device-address matching. It tells this block when an addressed transaction opens and which direction it has. It then hands over each received byte, and it requests a byte whenever the master clocks data out.

In a transaction opened for writing, the first byte loads an 8-bit register pointer. Every later byte, written or read, uses the pointer and then advances it by one, so bursts run through consecutive addresses. Sixteen byte-wide registers exist at pointer values 0x00 to 0x0F. Every other pointer value is reserved. The bus still treats a reserved access as normal: it is acknowledged, reads there give 0x00, and writes there leave storage untouched. Each data byte, implemented or reserved, raises a one-cycle completion event that carries no error.

A read-direction START keeps the pointer as it is. The usual sequence is therefore: write the address, send a repeated START for reading, then read from that address.

Top module: `i2cs_regaccess`

## Requirements
- R1: After synchronous reset, the pointer is 0x00, all 16 registers hold 0x00, no transaction is open and every output is 0.
- R2: A byte received while no transaction is open answers with `ack_vld_o`=1 and `ack_o`=0 one cycle later. A read request made while no data phase is open returns `rd_vld_o`=1 with 0x00. Neither case changes storage or the pointer, and neither raises `done_o`.
- R3: The first byte received after a write-direction START loads the pointer and is acknowledged (`ack_o`=1). It does not raise `done_o`.
- R4: A data byte received while the pointer is in 0x00..0x0F is stored in that register, and is acknowledged one cycle later with `done_o`=1.
- R5: A read request returns, one cycle later, `rd_vld_o`=1 with the content of the register the pointer selects, and raises `done_o`.
- R6: The pointer increases by one after every data byte, read or written, and wraps from 0xFF to 0x00.
- R7: An address byte in 0x10..0xFF is acknowledged like any other address byte.
- R8: A read while the pointer is in 0x10..0xFF returns 0x00.
- R9: A data byte received while the pointer is in 0x10..0xFF is acknowledged and raises `done_o`. No register changes.
- R10: A burst that starts below 0x10 and runs past 0x0F stores and returns real data up to 0x0F. From 0x10 on it returns 0x00 and drops writes.
- R11: A read-direction START leaves the pointer unchanged, so a read that follows an address write returns the register at the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse: an addressed transaction opens (START or repeated START) |
| start_rd_i | input | 1 | Direction that goes with `start_i`: 1 means read, 0 means write |
| wr_vld_i | input | 1 | One-cycle pulse: a byte has been received from the master |
| wr_data_i | input | 8 | Received byte |
| rd_req_i | input | 1 | One-cycle pulse: the master needs the next byte |
| ack_vld_o | output | 1 | Acknowledge decision is valid (one cycle after `wr_vld_i`) |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| rd_vld_o | output | 1 | Read byte is valid (one cycle after `rd_req_i`) |
| rd_data_o | output | 8 | Byte to send to the master |
| done_o | output | 1 | One-cycle event: a data access has completed without error |

## Verification
The assertions assume that the byte engine raises at most one of `start_i`, `wr_vld_i` and `rd_req_i` in any cycle. They also assume that every strobe lasts exactly one cycle. The bench issues one operation at a time and lowers every strobe at the next falling edge, so it always stays inside these assumptions. Random address bytes are mostly drawn near the 0x0F/0x10 boundary or near the 0xFF wrap point, so both edges come up often.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int PTR_W_DEF   = 8;
    localparam int DATA_W_DEF  = 8;
    localparam int NREGS_DEF   = 16;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic ack_vld;
        logic ack;
        logic rd_vld;
        logic done;
    } resp_flags_t;

    function automatic logic ptr_hits_reg(input logic [31:0] ptr, input int nregs);
        return ptr < 32'(nregs);
    endfunction
endpackage

// File: rtl/i2cs_ptr.sv
module i2cs_ptr
    import i2cs_pkg::*;
#(
    parameter int PTR_W = PTR_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             start_rd_i,
    input  logic             wr_vld_i,
    input  logic [PTR_W-1:0] wr_data_i,
    input  logic             rd_req_i,
    output logic [PTR_W-1:0] ptr_o,
    output phase_e           phase_o,
    output logic             data_step_o
);
    phase_e           phase_q;
    logic [PTR_W-1:0] ptr_q;

    assign data_step_o = (phase_q == PH_DATA) && (wr_vld_i || rd_req_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            ptr_q   <= '0;
        end else if (start_i) begin
            phase_q <= start_rd_i ? PH_DATA : PH_ADDR;
        end else if (wr_vld_i && phase_q == PH_ADDR) begin
            ptr_q   <= wr_data_i;
            phase_q <= PH_DATA;
        end else if (data_step_o) begin
            ptr_q   <= ptr_q + 1'b1;
        end
    end

    assign ptr_o   = ptr_q;
    assign phase_o = phase_q;

    // R6: every data byte advances the pointer by one, wrapping naturally
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA && !start_i && (wr_vld_i || rd_req_i))
        |=> ptr_q == $past(ptr_q) + 1'b1);

    // R11: a read-direction START keeps the pointer
    p_rd_start_keeps_ptr_r11: assert property (@(posedge clk) disable iff (rst)
        (start_i && start_rd_i) |=> (ptr_q == $past(ptr_q) && phase_q == PH_DATA));

    // R3: the address byte loads the pointer
    p_addr_load_r3: assert property (@(posedge clk) disable iff (rst)
        (!start_i && wr_vld_i && phase_q == PH_ADDR) |=> ptr_q == $past(wr_data_i));
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile
    import i2cs_pkg::*;
#(
    parameter int PTR_W  = PTR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int NREGS  = NREGS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PTR_W-1:0]  addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

    logic [NREGS-1:0][DATA_W-1:0] mem_q;
    logic                         hit;
    logic [IDX_W-1:0]             idx;

    assign hit = ptr_hits_reg(32'(addr_i), NREGS);
    assign idx = IDX_W'(addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                if (we_i && hit && idx == IDX_W'(i)) mem_q[i] <= wdata_i;
            end
        end
    end

    assign rdata_o = hit ? mem_q[idx] : '0;

    // R9: a write to reserved space leaves every register as it was
    p_rsv_write_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (we_i && !hit) |=> $stable(mem_q));

    // R4: a write to an implemented register lands there
    p_impl_write_r4: assert property (@(posedge clk) disable iff (rst)
        (we_i && hit) |=> mem_q[$past(idx)] == $past(wdata_i));
endmodule

// File: rtl/i2cs_regaccess.sv
module i2cs_regaccess
    import i2cs_pkg::*;
#(
    parameter int PTR_W  = PTR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int NREGS  = NREGS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              start_rd_i,
    input  logic              wr_vld_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_req_i,
    output logic              ack_vld_o,
    output logic              ack_o,
    output logic              rd_vld_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              done_o
);
    logic [PTR_W-1:0]  ptr;
    phase_e            phase;
    logic              data_step;
    logic              data_we;
    logic [DATA_W-1:0] rf_rdata;
    resp_flags_t       flags_q;
    logic [DATA_W-1:0] rd_data_q;

    i2cs_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .start_rd_i  (start_rd_i),
        .wr_vld_i    (wr_vld_i),
        .wr_data_i   (PTR_W'(wr_data_i)),
        .rd_req_i    (rd_req_i),
        .ptr_o       (ptr),
        .phase_o     (phase),
        .data_step_o (data_step)
    );

    assign data_we = wr_vld_i && !start_i && phase == PH_DATA;

    i2cs_regfile #(.PTR_W(PTR_W), .DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (ptr),
        .we_i    (data_we),
        .wdata_i (wr_data_i),
        .rdata_o (rf_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q   <= '0;
            rd_data_q <= '0;
        end else begin
            flags_q.ack_vld <= wr_vld_i;
            flags_q.ack     <= wr_vld_i && phase != PH_IDLE;
            flags_q.rd_vld  <= rd_req_i;
            flags_q.done    <= data_step && !start_i;
            rd_data_q       <= (rd_req_i && phase == PH_DATA) ? rf_rdata : '0;
        end
    end

    assign ack_vld_o = flags_q.ack_vld;
    assign ack_o     = flags_q.ack;
    assign rd_vld_o  = flags_q.rd_vld;
    assign done_o    = flags_q.done;
    assign rd_data_o = rd_data_q;

    // R8: a read in reserved space returns zero
    p_rsv_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && !ptr_hits_reg(32'(ptr), NREGS)) |=> rd_data_o == '0);

    // R7: any byte inside an open transaction is acknowledged
    p_open_ack_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_vld_i && phase != PH_IDLE) |=> (ack_vld_o && ack_o));

    // R2: a byte before any START is refused and completes nothing
    p_idle_nack_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_vld_i && !start_i && phase == PH_IDLE) |=> (ack_vld_o && !ack_o && !done_o));

    // R5: a read request always yields a read strobe the next cycle
    p_rd_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        rd_req_i |=> rd_vld_o);
endmodule

// File: tb/tb_i2cs_regaccess.sv
module tb_i2cs_regaccess;
    logic       clk = 1'b0;
    logic       rst;
    logic       start_i, start_rd_i, wr_vld_i, rd_req_i;
    logic [7:0] wr_data_i;
    logic       ack_vld_o, ack_o, rd_vld_o, done_o;
    logic [7:0] rd_data_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    // reference model state
    logic [7:0] m_mem [16];
    logic [7:0] m_ptr;
    int         m_phase; // 0 idle, 1 address, 2 data

    always #4 clk = ~clk;

    i2cs_regaccess dut (
        .clk(clk), .rst(rst), .start_i(start_i), .start_rd_i(start_rd_i),
        .wr_vld_i(wr_vld_i), .wr_data_i(wr_data_i), .rd_req_i(rd_req_i),
        .ack_vld_o(ack_vld_o), .ack_o(ack_o), .rd_vld_o(rd_vld_o),
        .rd_data_o(rd_data_o), .done_o(done_o)
    );

    function automatic logic [7:0] m_read(input logic [7:0] p);
        return (p < 8'h10) ? m_mem[p[3:0]] : 8'h00;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic do_start(input logic rd);
        @(negedge clk);
        start_i = 1'b1; start_rd_i = rd;
        @(negedge clk);
        start_i = 1'b0; start_rd_i = 1'b0;
        check("R2/R5 no strobe on START", {ack_vld_o, rd_vld_o, done_o}, 0);
        m_phase = rd ? 2 : 1;
    endtask

    task automatic do_wr(input logic [7:0] b, input string req);
        int exp_ack, exp_done;
        exp_ack  = (m_phase != 0);
        exp_done = (m_phase == 2);
        @(negedge clk);
        wr_vld_i = 1'b1; wr_data_i = b;
        @(negedge clk);
        wr_vld_i = 1'b0;
        check(req, {ack_vld_o, ack_o, done_o}, {1'b1, exp_ack[0], exp_done[0]});
        if (m_phase == 1) begin
            m_ptr = b; m_phase = 2;
        end else if (m_phase == 2) begin
            if (m_ptr < 8'h10) m_mem[m_ptr[3:0]] = b;
            m_ptr = m_ptr + 8'd1;
        end
    endtask

    task automatic do_rd(input string req);
        logic [7:0] exp_d;
        int exp_done;
        exp_d    = (m_phase == 2) ? m_read(m_ptr) : 8'h00;
        exp_done = (m_phase == 2);
        @(negedge clk);
        rd_req_i = 1'b1;
        @(negedge clk);
        rd_req_i = 1'b0;
        check(req, {rd_vld_o, done_o, rd_data_o}, {1'b1, exp_done[0], exp_d});
        if (m_phase == 2) m_ptr = m_ptr + 8'd1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed_dummy;
        start_i = 0; start_rd_i = 0; wr_vld_i = 0; rd_req_i = 0; wr_data_i = 0;
        rst = 1'b1;
        for (int i = 0; i < 16; i++) m_mem[i] = 8'h00;
        m_ptr = 8'h00; m_phase = 0;
        seed_dummy = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state at the ports
        check("R1 outputs after reset", {ack_vld_o, ack_o, rd_vld_o, done_o, rd_data_o}, 0);

        // R2: before any START
        do_wr(8'h05, "R2 idle byte NACK");
        do_rd("R2 idle read zero");

        // R1 registers are zero, R3 address load, R11 read start keeps pointer
        do_start(1'b0); do_wr(8'h00, "R3 address byte");
        do_start(1'b1);
        for (int i = 0; i < 16; i++) do_rd("R1 register reset value");

        // R4, R11: write then repeated-start read
        do_start(1'b0); do_wr(8'h07, "R3 address 0x07"); do_wr(8'hA5, "R4 write 0x07");
        do_start(1'b0); do_wr(8'h07, "R3 address 0x07");
        do_start(1'b1); do_rd("R11 R5 read back 0x07");

        // R7, R8, R9: reserved address
        do_start(1'b0); do_wr(8'h47, "R7 reserved address ACK");
        do_wr(8'h3C, "R9 reserved write ACK");
        do_start(1'b0); do_wr(8'h47, "R7 reserved address ACK");
        do_start(1'b1); do_rd("R8 reserved read zero");
        do_start(1'b0); do_wr(8'h07, "R3 address");
        do_start(1'b1); do_rd("R9 no alias on 0x07");

        // R10: burst across 0x0F/0x10
        do_start(1'b0); do_wr(8'h0E, "R3 address 0x0E");
        do_wr(8'h11, "R10 write 0x0E"); do_wr(8'h22, "R10 write 0x0F");
        do_wr(8'h33, "R10 write 0x10 dropped"); do_wr(8'h44, "R10 write 0x11 dropped");
        do_start(1'b0); do_wr(8'h0E, "R3 address 0x0E");
        do_start(1'b1);
        for (int i = 0; i < 4; i++) do_rd("R10 burst read across boundary");
        do_start(1'b0); do_wr(8'h00, "R3 address 0x00");
        do_start(1'b1); do_rd("R10 0x00 untouched"); do_rd("R10 0x01 untouched");

        // R6: wrap 0xFF -> 0x00
        do_start(1'b0); do_wr(8'hFF, "R7 address 0xFF");
        do_wr(8'h99, "R9 write 0xFF dropped"); do_wr(8'h5A, "R6 write after wrap to 0x00");
        do_start(1'b0); do_wr(8'hFE, "R7 address 0xFE");
        do_start(1'b1);
        for (int i = 0; i < 3; i++) do_rd("R6 read across wrap");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom % 10);
            if (op == 0) begin
                do_start(1'($urandom % 2));
            end else if (op < 6) begin
                logic [7:0] b;
                int sel;
                sel = int'($urandom % 4);
                b = (sel == 0) ? 8'($urandom) :
                    (sel == 3) ? 8'(8'hF8 + ($urandom % 8)) : 8'($urandom % 24);
                do_wr(b, (m_phase == 2) ? ((m_ptr < 8'h10) ? "R4 random write" : "R9 random write")
                                        : "R3 random address");
            end else begin
                do_rd((m_phase == 2 && m_ptr >= 8'h10) ? "R8 random read" : "R5 random read");
            end
        end

        finish_run();
    end
endmodule